// File: doc/BRIEF.md
# Twister Output Tempering Pipeline

This block takes raw 32-bit state words from a twisted feedback generator's update pipeline and scrambles each one into a well-distributed 32-bit random number. It applies a fixed series of four shift/mask/XOR steps. Each word arrives with a valid flag. The tempered word leaves with its own valid flag a fixed number of cycles later.

The stage takes a new word on every clock and never pushes back on its source. This keeps it in lock step with the state update logic that feeds it. The four steps can be split across one, two or three register stages. Three is the ceiling: the update pipeline it pairs with is no deeper than that, so a deeper split would gain nothing.

Top module: `mt_temper_pipe`

## Requirements
- R1: For every accepted word x, the emitted word equals f(x), where f applies the four steps of R2 to R5 in that order, each step acting on the result of the one before.
- R2: The first step replaces y with y XOR (y >> 11), a logical right shift.
- R3: The second step replaces y with y XOR ((y << 7) AND 0x9D2C5680).
- R4: The third step replaces y with y XOR ((y << 15) AND 0xEFC60000).
- R5: The fourth step replaces y with y XOR (y >> 18), a logical right shift.
- R6: `out_valid_o` is `in_valid_i` delayed by exactly NUM_STAGES clock cycles. The matching word appears in that same cycle. Words entered with `in_valid_i` low produce no valid output.
- R7: A new word is accepted on every clock cycle, back to back, with no stall signal. Every accepted word comes out in input order.
- R8: While `rst_n` is low, `out_valid_o` is 0. Words that were in flight when reset was asserted are discarded and never emitted.
- R9: NUM_STAGES must be 1, 2 or 3 and WORD_W must be 32. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; clears every valid flag |
| in_valid_i | input | 1 | Raw state word present this cycle |
| in_word_i | input | WORD_W | Raw state word |
| out_valid_o | output | 1 | Tempered word present this cycle |
| out_word_o | output | WORD_W | Tempered random number |

## Verification
The bench builds three copies of the block side by side, one for each legal NUM_STAGES value (1, 2 and 3), and feeds all three the same stimulus. This covers every way the four steps can be split across registers, including the case where two steps share one stage with no register between them. Each copy is checked at its own latency. Walking single-bit words, solid and alternating patterns, valid gaps and a reset in mid-stream expose wrong shift amounts, wrong masks, misplaced registers and valid flags that leak through reset.

// File: rtl/mt_temper_pkg.sv
package mt_temper_pkg;

   localparam int unsigned TEMPER_W   = 32;
   localparam int unsigned STEP_COUNT = 4;
   localparam int unsigned MAX_STAGES = 3;

   localparam logic [TEMPER_W-1:0] MASK_B = 32'h9D2C5680;
   localparam logic [TEMPER_W-1:0] MASK_C = 32'hEFC60000;

   localparam int unsigned SHIFT_U = 11;
   localparam int unsigned SHIFT_S = 7;
   localparam int unsigned SHIFT_T = 15;
   localparam int unsigned SHIFT_L = 18;

   // Whether a pipeline register follows tempering step 'step' for a given depth.
   function automatic bit reg_after_step(input int unsigned stages, input int unsigned step);
      case (stages)
         1:       return (step == 3);
         2:       return (step == 1) || (step == 3);
         default: return (step >= 1);
      endcase
   endfunction

endpackage

// File: rtl/mt_temper_step.sv
module mt_temper_step
   import mt_temper_pkg::*;
#(
   parameter int unsigned STEP_IDX = 0,
   parameter int unsigned WORD_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_i,
   input  logic [WORD_W-1:0] y_i,
   output logic [WORD_W-1:0] y_o
);

   generate
      if (STEP_IDX == 0) begin : g_shr_u
         assign y_o = y_i ^ (y_i >> SHIFT_U);
         // Upper SHIFT_U bits are untouched by a right shift XOR
         p_top_bits_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            v_i |-> ((y_o ^ y_i) >> (WORD_W - SHIFT_U)) == '0);
      end else if (STEP_IDX == 1) begin : g_shl_s
         assign y_o = y_i ^ ((y_i << SHIFT_S) & MASK_B);
         p_mask_b_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            v_i |-> ((y_o ^ y_i) & ~MASK_B) == '0);
      end else if (STEP_IDX == 2) begin : g_shl_t
         assign y_o = y_i ^ ((y_i << SHIFT_T) & MASK_C);
         p_mask_c_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            v_i |-> ((y_o ^ y_i) & ~MASK_C) == '0);
      end else begin : g_shr_l
         assign y_o = y_i ^ (y_i >> SHIFT_L);
         p_top_bits_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            v_i |-> ((y_o ^ y_i) >> (WORD_W - SHIFT_L)) == '0);
      end
   endgenerate

endmodule

// File: rtl/mt_temper_stage.sv
module mt_temper_stage #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_d,
   input  logic [WORD_W-1:0] y_d,
   output logic              v_q,
   output logic [WORD_W-1:0] y_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
   end

   // Data carries no reset: it is qualified by v_q.
   always_ff @(posedge clk) begin
      y_q <= y_d;
   end

   p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (v_q == $past(v_d)));

endmodule

// File: rtl/mt_temper_pipe.sv
module mt_temper_pipe
   import mt_temper_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned NUM_STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic [WORD_W-1:0] in_word_i,
   output logic              out_valid_o,
   output logic [WORD_W-1:0] out_word_o
);

   localparam int unsigned NSTEP = STEP_COUNT;

   // R9: elaboration-time legality checks
   generate
      if (WORD_W != TEMPER_W) begin : g_bad_width
         $error("mt_temper_pipe: WORD_W must be %0d", TEMPER_W);
      end
      if (NUM_STAGES < 1 || NUM_STAGES > MAX_STAGES) begin : g_bad_depth
         $error("mt_temper_pipe: NUM_STAGES must be 1..%0d", MAX_STAGES);
      end
   endgenerate

   logic              chain_v [NSTEP+1];
   logic [WORD_W-1:0] chain_y [NSTEP+1];

   assign chain_v[0] = in_valid_i;
   assign chain_y[0] = in_word_i;

   generate
      for (genvar k = 0; k < NSTEP; k++) begin : g_step
         logic [WORD_W-1:0] stepped;

         mt_temper_step #(.STEP_IDX(k), .WORD_W(WORD_W)) u_step (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (chain_v[k]),
            .y_i   (chain_y[k]),
            .y_o   (stepped)
         );

         if (reg_after_step(NUM_STAGES, k)) begin : g_reg
            mt_temper_stage #(.WORD_W(WORD_W)) u_stage (
               .clk   (clk),
               .rst_n (rst_n),
               .v_d   (chain_v[k]),
               .y_d   (stepped),
               .v_q   (chain_v[k+1]),
               .y_q   (chain_y[k+1])
            );
         end else begin : g_wire
            assign chain_v[k+1] = chain_v[k];
            assign chain_y[k+1] = stepped;
         end
      end
   endgenerate

   assign out_valid_o = chain_v[NSTEP];
   assign out_word_o  = chain_y[NSTEP];

   // R8: reset holds the output valid low (checked without disable)
   p_reset_clears_r8: assert property (@(posedge clk)
      !rst_n |-> !out_valid_o);

endmodule

// File: tb/mt_temper_pipe_tb.sv
module mt_temper_pipe_tb;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_v = 1'b0;
   logic [W-1:0] in_d = '0;

   logic         ov [3];
   logic [W-1:0] od [3];

   int n_checks = 0;
   int n_fails  = 0;

   // lag history: hv[i]/hd[i] = input driven i+1 negedges ago
   logic         hv [3];
   logic [W-1:0] hd [3];

   always #10 clk = ~clk;  // 50 MHz

   mt_temper_pipe #(.WORD_W(W), .NUM_STAGES(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_v), .in_word_i(in_d),
      .out_valid_o(ov[0]), .out_word_o(od[0]));
   mt_temper_pipe #(.WORD_W(W), .NUM_STAGES(2)) u_dut2 (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_v), .in_word_i(in_d),
      .out_valid_o(ov[1]), .out_word_o(od[1]));
   mt_temper_pipe #(.WORD_W(W), .NUM_STAGES(3)) u_dut3 (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_v), .in_word_i(in_d),
      .out_valid_o(ov[2]), .out_word_o(od[2]));

   function automatic logic [W-1:0] model(input logic [W-1:0] x);
      logic [W-1:0] y;
      y = x;
      y = y ^ (y >> 11);                    // R2
      y = y ^ ((y << 7) & 32'h9D2C5680);    // R3
      y = y ^ ((y << 15) & 32'hEFC60000);   // R4
      y = y ^ (y >> 18);                    // R5
      return y;
   endfunction

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_word(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_hist();
      for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hd[i] = '0; end
   endtask

   // Compare all three instances against the lagged history, then drive.
   task automatic cycle(input logic v, input logic [W-1:0] d, input string tag);
      @(negedge clk);
      for (int s = 0; s < 3; s++) begin
         check_bit({tag, " R6 valid latency"}, ov[s], hv[s]);
         if (hv[s]) check_word({tag, " R1 R2 R3 R4 R5 data"}, od[s], model(hd[s]));
      end
      for (int i = 2; i > 0; i--) begin hv[i] = hv[i-1]; hd[i] = hd[i-1]; end
      hv[0] = v; hd[0] = d;
      in_v = v; in_d = d;
   endtask

   task automatic flush(input string tag);
      for (int i = 0; i < 4; i++) cycle(1'b0, '0, tag);
   endtask

   task automatic t_reset();
      clear_hist();
      in_v = 1'b1; in_d = 32'hFFFFFFFF;
      repeat (3) @(negedge clk);
      for (int s = 0; s < 3; s++) check_bit("R8 valid low in reset", ov[s], 1'b0);
      in_v = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      flush("reset release");
   endtask

   task automatic t_walking_bits();
      for (int b = 0; b < W; b++) cycle(1'b1, 32'h1 << b, "R7 walking bit");
      flush("R7 walking drain");
   endtask

   task automatic t_patterns();
      cycle(1'b1, 32'h00000000, "zero");
      cycle(1'b1, 32'hFFFFFFFF, "ones");
      cycle(1'b1, 32'hAAAAAAAA, "alt a");
      cycle(1'b1, 32'h55555555, "alt 5");
      cycle(1'b1, 32'h12345678, "mixed");
      cycle(1'b1, 32'hDEADBEEF, "mixed2");
      flush("pattern drain");
   endtask

   task automatic t_gaps();
      logic [W-1:0] lf = 32'hACE1F00D;
      for (int i = 0; i < 40; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         cycle((i % 3) != 1, lf ^ (i * 32'h9E3779B9), "R6 gapped");
      end
      flush("gap drain");
   endtask

   task automatic t_mid_reset();
      cycle(1'b1, 32'hCAFEF00D, "pre reset");
      cycle(1'b1, 32'h0BADC0DE, "pre reset");
      #2 rst_n = 1'b0;
      #1;
      for (int s = 0; s < 3; s++) check_bit("R8 in-flight dropped", ov[s], 1'b0);
      in_v = 1'b0;
      clear_hist();
      @(negedge clk);
      rst_n = 1'b1;
      flush("R8 after reset");
      cycle(1'b1, 32'h31415926, "R8 resume");
      flush("R8 resume drain");
   endtask

   initial begin
      #5_000_000;
      n_fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      t_reset();
      t_walking_bits();
      t_patterns();
      t_gaps();
      t_mid_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule